// File: doc/BRIEF.md
# Coprocessor Shared-RAM Host Port

This block sits between a host bus and an attached I/O coprocessor. The host reaches the coprocessor's private RAM indirectly: it loads a 16-bit pointer as two separate byte registers, then reads or writes a data register that maps to the RAM byte at that pointer. With the step-after-access control bit set, the pointer advances after every data access. Whole code images can then be uploaded, read back or compared by repeated access to the data register alone. The pointer wraps from 0xFFFF to 0x0000.

A single control/status register does four jobs. It holds the line that keeps the coprocessor in reset or lets it run. It holds the step-after-access enable. It has a doorbell bit that sends a one-cycle attention pulse to the coprocessor. It shows two event flags that the coprocessor raises. One flag means outbound work has finished and the other means an inbound message is waiting. Both flags drive one host interrupt line. Each flag clears when the host writes a one to its bit. The host writes the run and step bits in the same byte, so it can clear a flag without stopping the coprocessor.

A common host sequence checks that the coprocessor is alive. The host reads a fixed RAM byte that the coprocessor sets to 0xFF, then writes it back to zero.

Top module: `cop_ram_port`

## Requirements
- R1: After reset the pointer is 0x0000, `cop_run`, `cop_doorbell` and `host_irq` are low, and the control register reads 0x00.
- R2: A write to offset 0 loads pointer bits 7:0 and a write to offset 1 loads bits 15:8; `ram_addr` shows the pointer from the next cycle, and reads of offsets 0 and 1 return those bytes without changing the pointer.
- R3: A write to offset 2 asserts `ram_wr_en` in the same cycle, with `ram_wdata` equal to the host byte and `ram_addr` equal to the pointer. A read of offset 2 asserts `ram_rd_en` and returns `ram_rdata` on `host_rdata` in that same cycle.
- R4: When control bit 1 (step) is set, each data access moves the pointer up by one from the next cycle, wrapping 0xFFFF to 0x0000; when it is clear, the pointer holds.
- R5: Control bit 0 (run) drives `cop_run` from the cycle after the write and reads back at bit 0.
- R6: Writing control bit 2 as one gives a pulse on `cop_doorbell` of exactly one cycle, in the cycle after the write; bit 2 always reads zero.
- R7: `cop_evt[0]` high at a clock edge sets control bit 4, and `cop_evt[1]` sets bit 5; a flag stays set until the host clears it.
- R8: Writing one to bit 4 or 5 clears that flag and writing zero leaves it; if the event and the clear land in the same cycle, the flag stays set.
- R9: `host_irq` is high exactly when bit 4 or bit 5 is set.
- R10: With `host_sel` low, or on a read of a register, the pointer, the control bits and the RAM strobes are unchanged, and `host_rdata` is zero when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe for this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 2 | Register offset: 0 pointer low, 1 pointer high, 2 data, 3 control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| ram_addr | output | 16 | RAM byte address |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid in the same cycle |
| cop_run | output | 1 | Coprocessor release (0 holds it stopped) |
| cop_doorbell | output | 1 | One-cycle attention pulse to the coprocessor |
| cop_evt | input | 2 | Event inputs: bit 0 completion, bit 1 new message |
| host_irq | output | 1 | Merged host interrupt |

## Verification
Two situations are hardest to reach from the ports. The first is a coprocessor event that arrives on the exact edge where the host's clear write lands. The bench reaches it by raising `cop_evt[1]` in the same driven cycle as the control write. The second is the pointer wrap. The bench loads 0xFFFF through the two byte registers and then makes a stepping data access. A per-cycle behavioural model follows the pointer, the flags and a shadow of RAM, and it compares every port on every clock.

// File: rtl/cop_port_pkg.sv
package cop_port_pkg;
  typedef enum logic [1:0] {
    REG_PTR_LO = 2'd0,
    REG_PTR_HI = 2'd1,
    REG_DATA   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int BIT_RUN  = 0;
  localparam int BIT_STEP = 1;
  localparam int BIT_BELL = 2;
  localparam int BIT_EV0  = 4;
  localparam int NUM_EVT  = 2;

  // Assemble the control/status byte seen by a host read.
  function automatic logic [7:0] ctrl_image(input logic run, input logic step,
                                            input logic [NUM_EVT-1:0] flags);
    logic [7:0] b;
    b = '0;
    b[BIT_RUN]  = run;
    b[BIT_STEP] = step;
    b[BIT_EV0 +: NUM_EVT] = flags;
    return b;
  endfunction
endpackage

// File: rtl/cop_addr_ctr.sv
module cop_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step,
  input  logic [7:0]    wbyte,
  output logic [AW-1:0] ptr
);
  localparam int HI_W = AW - 8;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr[7:0] <= wbyte;
    end else if (ld_hi) begin
      ptr[AW-1:8] <= wbyte[HI_W-1:0];
    end else if (step) begin
      ptr <= ptr_next(ptr);
    end
  end

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lo && !ld_hi) |=> (ptr == ptr_next($past(ptr))));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_lo && !ld_hi) |=> $stable(ptr));
  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (ptr[7:0] == $past(wbyte)) && (ptr[AW-1:8] == $past(ptr[AW-1:8])));
endmodule

// File: rtl/cop_ctrl_reg.sv
module cop_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wbits,
  output logic       run,
  output logic       step_en,
  output logic       bell
);
  import cop_port_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      step_en <= 1'b0;
      bell    <= 1'b0;
    end else begin
      bell <= wr && wbits[BIT_BELL];
      if (wr) begin
        run     <= wbits[BIT_RUN];
        step_en <= wbits[BIT_STEP];
      end
    end
  end

  p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (run == $past(wbits[BIT_RUN])));
  p_bell_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wbits[BIT_BELL]) |=> bell);
  p_bell_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && wbits[BIT_BELL]) |=> !bell);
endmodule

// File: rtl/cop_evt_flags.sv
module cop_evt_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !flag[i]);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
  end

  assign irq = |flag;

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> irq);
endmodule

// File: rtl/cop_ram_port.sv
module cop_ram_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [1:0]    host_off,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_wr_en,
  output logic          ram_rd_en,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          cop_run,
  output logic          cop_doorbell,
  input  logic [1:0]    cop_evt,
  output logic          host_irq
);
  import cop_port_pkg::*;

  localparam int HI_W = AW - 8;

  reg_sel_e           sel_reg;
  logic               wr_hit, rd_hit, data_acc, ctrl_wr;
  logic               step_en;
  logic [NUM_EVT-1:0] flags, clr_req;

  assign sel_reg  = reg_sel_e'(host_off);
  assign wr_hit   = host_sel && host_wr;
  assign rd_hit   = host_sel && !host_wr;
  assign data_acc = host_sel && (sel_reg == REG_DATA);
  assign ctrl_wr  = wr_hit && (sel_reg == REG_CTRL);
  assign clr_req  = ctrl_wr ? host_wdata[BIT_EV0 +: NUM_EVT] : '0;

  cop_addr_ctr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (wr_hit && (sel_reg == REG_PTR_LO)),
    .ld_hi (wr_hit && (sel_reg == REG_PTR_HI)),
    .step  (data_acc && step_en),
    .wbyte (host_wdata),
    .ptr   (ram_addr)
  );

  cop_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctrl_wr),
    .wbits   (host_wdata[2:0]),
    .run     (cop_run),
    .step_en (step_en),
    .bell    (cop_doorbell)
  );

  cop_evt_flags #(.N(NUM_EVT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cop_evt),
    .clr   (clr_req),
    .flag  (flags),
    .irq   (host_irq)
  );

  assign ram_wr_en = wr_hit && data_acc;
  assign ram_rd_en = rd_hit && data_acc;
  assign ram_wdata = host_wdata;

  always_comb begin
    host_rdata = '0;
    if (rd_hit) begin
      case (sel_reg)
        REG_PTR_LO: host_rdata = ram_addr[7:0];
        REG_PTR_HI: host_rdata = {{(8-HI_W){1'b0}}, ram_addr[AW-1:8]};
        REG_DATA:   host_rdata = ram_rdata;
        default:    host_rdata = ctrl_image(cop_run, step_en, flags);
      endcase
    end
  end

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |=> ($stable(cop_run) && $stable(ram_addr)));
  p_bell_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel_reg == REG_CTRL) |-> !host_rdata[BIT_BELL]);
endmodule

// File: tb/cop_ram_port_tb.sv
`timescale 1ns/100ps
module cop_ram_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_off = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [15:0] ram_addr;
  logic        ram_wr_en, ram_rd_en;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        cop_run, cop_doorbell, host_irq;
  logic [1:0]  cop_evt = 2'b00;

  logic [7:0] bram [0:255];

  always #2 clk = ~clk;

  cop_ram_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ram_addr(ram_addr), .ram_wr_en(ram_wr_en), .ram_rd_en(ram_rd_en),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cop_run(cop_run),
    .cop_doorbell(cop_doorbell), .cop_evt(cop_evt), .host_irq(host_irq)
  );

  assign ram_rdata = bram[ram_addr[7:0]];
  always @(posedge clk) if (ram_wr_en) bram[ram_addr[7:0]] <= ram_wdata;

  // Behavioural reference state.
  int   m_ptr, m_run, m_step, m_bell, m_f0, m_f1;
  int   m_mem [int];
  int   checks = 0, errors = 0;
  bit   done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mem_rd(input int a);
    int k = a & 255;
    return m_mem.exists(k) ? m_mem[k] : 0;
  endfunction

  function automatic int exp_read(input int off);
    case (off)
      0: return m_ptr & 255;
      1: return (m_ptr >> 8) & 255;
      2: return mem_rd(m_ptr);
      default: return m_run | (m_step << 1) | (m_f0 << 4) | (m_f1 << 5);
    endcase
  endfunction

  // One cycle: drive, check same-cycle outputs, clock, update model, check registered outputs.
  task automatic cyc(input bit sel, input bit wr, input int off, input int wd, input int ev);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_off = off[1:0]; host_wdata = wd[7:0]; cop_evt = ev[1:0];
    #1;
    chk("R2 ram_addr", ram_addr, m_ptr);
    chk("R3 wr_en", ram_wr_en, (sel && wr && off == 2) ? 1 : 0);
    chk("R3 rd_en", ram_rd_en, (sel && !wr && off == 2) ? 1 : 0);
    if (sel && wr && off == 2) chk("R3 wdata", ram_wdata, wd);
    chk("R10 rdata", host_rdata, (sel && !wr) ? exp_read(off) : 0);
    @(posedge clk);
    m_bell = 0;
    if (sel && wr) begin
      case (off)
        0: m_ptr = (m_ptr & 16'hFF00) | wd;
        1: m_ptr = (m_ptr & 16'h00FF) | (wd << 8);
        2: begin m_mem[m_ptr & 255] = wd; if (m_step != 0) m_ptr = (m_ptr + 1) % 65536; end
        default: begin
          m_run = wd & 1; m_step = (wd >> 1) & 1; m_bell = (wd >> 2) & 1;
          if (wd[4]) m_f0 = 0;
          if (wd[5]) m_f1 = 0;
        end
      endcase
    end else if (sel && off == 2 && m_step != 0) begin
      m_ptr = (m_ptr + 1) % 65536;
    end
    if (ev[0]) m_f0 = 1;
    if (ev[1]) m_f1 = 1;
    #1;
    chk("R5 run", cop_run, m_run);
    chk("R6 doorbell", cop_doorbell, m_bell);
    chk("R9 irq", host_irq, (m_f0 | m_f1));
  endtask

  task automatic wr_reg(input int off, input int wd); cyc(1, 1, off, wd, 0); endtask
  task automatic rd_reg(input int off); cyc(1, 0, off, 0, 0); endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bram[i] = 8'h00;
    m_ptr = 0; m_run = 0; m_step = 0; m_bell = 0; m_f0 = 0; m_f1 = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 ptr", ram_addr, 0);
    chk("R1 run", cop_run, 0);
    chk("R1 bell", cop_doorbell, 0);
    chk("R1 irq", host_irq, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_reg(3);                                  // R1 control reads 0

    // R2: pointer bytes
    wr_reg(0, 8'h34); wr_reg(1, 8'h12);
    rd_reg(0); rd_reg(1);
    chk("R2 ptr loaded", ram_addr, 16'h1234);

    // R3/R4: data access with step off, pointer holds
    wr_reg(2, 8'hA5); rd_reg(2);
    chk("R4 hold", ram_addr, 16'h1234);

    // R5/R4: run and step on, block upload and readback
    wr_reg(3, 8'h03);
    for (int i = 0; i < 4; i++) wr_reg(2, 8'h10 + i);
    chk("R4 step", ram_addr, 16'h1238);
    wr_reg(0, 8'h34);
    for (int i = 0; i < 4; i++) rd_reg(2);

    // R4: wrap
    wr_reg(0, 8'hFF); wr_reg(1, 8'hFF);
    wr_reg(2, 8'h5A);
    chk("R4 wrap", ram_addr, 16'h0000);
    wr_reg(0, 8'hFF); wr_reg(1, 8'hFF); rd_reg(2);
    chk("R4 wrap rd", ram_addr, 16'h0000);

    // R6: doorbell single pulse, reads zero
    wr_reg(3, 8'h07);
    rd_reg(3);
    rd_reg(3);

    // R7/R9: events
    cyc(0, 0, 0, 0, 1);
    rd_reg(3);
    wr_reg(3, 8'h03);                           // R8 zero leaves flag
    wr_reg(3, 8'h13);                           // R8 clear bit4, run stays
    rd_reg(3);
    cyc(0, 0, 0, 0, 2);
    cyc(1, 1, 3, 8'h23, 2);                     // R8 set wins over clear
    rd_reg(3);
    wr_reg(3, 8'h23);
    rd_reg(3);
    cyc(1, 1, 3, 8'h33, 3);                     // R8 both collide

    // R10: unselected writes and register reads change nothing
    cyc(0, 1, 3, 8'h00, 0);
    cyc(0, 1, 2, 8'hEE, 0);
    cyc(0, 1, 0, 8'h99, 0);
    rd_reg(3); rd_reg(0); rd_reg(1);

    // Liveness handshake: coprocessor marks 0xFF, host checks and clears
    wr_reg(3, 8'h31);
    wr_reg(0, 8'h40); wr_reg(1, 8'h00);
    @(negedge clk); bram[8'h40] = 8'hFF; m_mem[8'h40] = 8'hFF;
    rd_reg(2); wr_reg(2, 8'h00); rd_reg(2);

    done = 1;
    summary();
  end
endmodule